// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block turns single requests from an on-chip port into timed read and write cycles on an asynchronous external bus. The bus can serve static RAM, EPROM, flash, or register banks inside programmable logic. On the external side it drives an address, a 32-bit data bus split into an output half, an input half and a driver enable, per-lane active-low byte enables, and three active-low strobes: output enable, read strobe and write strobe. A ready input lets a slow device stretch the strobe phase.

Every access runs setup, strobe and hold phases, and each phase length is set by a configuration input. When a write follows a read, the controller first inserts a programmable number of quiet turnaround cycles, so the device's read driver and the controller's write driver never overlap. The external device can be 8, 16 or 32 bits wide. Narrow devices sit on the low lanes in little-endian mode and on the high lanes in big-endian mode. Each request is one beat. Request data is right-justified, and the block steers it onto the correct lanes.

The sequencer states are IDLE, TURN, SETUP, STROBE and HOLD. Its transitions are:
- IDLE→TURN: accept a write after a read while the turnaround count is non-zero.
- IDLE→SETUP: accept any other request.
- TURN→SETUP: the turnaround count is used up.
- SETUP→STROBE: the setup count is used up.
- STROBE→STROBE: a wait state, taken when ready is low on the final strobe cycle.
- STROBE→HOLD: the strobe ends and the hold count is non-zero.
- STROBE→IDLE: the strobe ends and the hold count is zero.
- HOLD→IDLE: the hold count is used up.

Top module: `async_mem_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the access completes.
- R2: After acceptance, the phases run in this order: TURN (only if R8 applies), SETUP for `cfg_setup` cycles, STROBE for `cfg_strobe` cycles plus wait states, then HOLD for `cfg_hold` cycles. A value of 0 for setup or strobe counts as 1. A hold of 0 skips HOLD.
- R3: `mem_oe_n` is low in every SETUP, STROBE and HOLD cycle of a read, and high at all other times.
- R4: `mem_re_n` is low only in the STROBE cycles of a read.
- R5: `mem_we_n` is low only in the STROBE cycles of a write.
- R6: Each cycle in which `mem_rdy` is low on the final strobe cycle adds one more strobe cycle.
- R7: `done` is a one-cycle pulse in the first idle cycle after the last active cycle. For a read, `rdata` holds the bus value captured on the final strobe cycle in which `mem_rdy` was high.
- R8: A write whose most recent completed access was a read starts with `cfg_turn` TURN cycles. During TURN all strobes are high, all byte enables are high and the driver is off. With `cfg_turn` = 0, or for any other pairing of accesses, no TURN cycles are inserted.
- R9: `mem_dq_oe` is high exactly in the SETUP, STROBE and HOLD cycles of a write.
- R10: Encodings are `cfg_width` 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and `req_size` 0 = byte, 1 = half, 2 = word. An access wider than the device is cut to the device width, and the offset within the device word is `req_addr[1:0]` modulo the device width, aligned down to the access size. In little-endian mode, data byte i sits at device byte address offset+i, and byte address a is driven on lane a.
- R11: In big-endian mode (`cfg_big_endian` = 1), data byte i (0 = least significant) sits at device byte address offset+size−1−i, and byte address a is driven on lane 3−a. A 16-bit device therefore uses lanes [31:16] and an 8-bit device uses [31:24].
- R12: In SETUP, STROBE and HOLD, `mem_be_n[L]` is low only for a lane L that carries data byte i with `req_be[i]` = 1. At all other times every bit of `mem_be_n` is high.
- R13: Read data in `rdata` is right-justified, and bytes above the effective access size read as zero.
- R14: `mem_addr` equals the accepted `req_addr` in every cycle from acceptance to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Right-justified write data |
| req_be | input | 4 | Byte enables for right-justified data bytes |
| done | output | 1 | Completion pulse |
| rdata | output | 32 | Right-justified read data |
| cfg_width | input | 2 | External device width code |
| cfg_big_endian | input | 1 | Lane placement order |
| cfg_setup | input | CW | Setup cycles |
| cfg_strobe | input | CW | Strobe cycles |
| cfg_turn | input | CW | Read-to-write turnaround cycles |
| cfg_hold | input | HW | Hold cycles |
| mem_addr | output | AW | External address |
| mem_dq_out | output | 32 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 32 | Data bus input value |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 4 | Byte-lane enables, active low |
| mem_rdy | input | 1 | Ready from the device |

## Verification
The first sweep covers every combination of endianness, device width, access size, address offset and direction. It shows whether each data byte lands on the right lane, whether the byte enables follow that lane, and whether truncation and zero-filling of read data are correct. Because reads and writes alternate in this sweep, the read-then-write turnaround is exercised on every other access. The second sweep varies setup, strobe, hold and wait-state counts with the lane settings fixed. Comparing strobes cycle by cycle against arithmetic phase boundaries separates a phase length error from a wait-state error and from a hold-skip error. Separate runs of back-to-back writes and of writes after reads with a long turnaround show whether the gap is keyed to the previous access and not inserted everywhere.

// File: rtl/amc_pkg.sv
package amc_pkg;
    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4
    } amc_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } amc_size_e;
endpackage

// File: rtl/amc_lanes.sv
module amc_lanes
    import amc_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       width,
    input  logic             big,
    input  logic [1:0]       addr_lo,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    bus_in,
    output logic [DW-1:0]    bus_wdata,
    output logic [LANES-1:0] bus_be,
    output logic [DW-1:0]    rdata
);
    logic [2:0]       n_bytes;
    logic [2:0]       m_bytes;
    logic [2:0]       e_bytes;
    logic [1:0]       offs;
    logic [1:0]       sh;
    logic [2:0]       sh_big;
    logic [LANES-1:0] bmask;
    logic [DW-1:0]    emask;

    always_comb begin
        unique case (size)
            2'd0:    n_bytes = 3'd1;
            2'd1:    n_bytes = 3'd2;
            default: n_bytes = 3'd4;
        endcase
        unique case (width)
            2'd0:    m_bytes = 3'd1;
            2'd1:    m_bytes = 3'd2;
            default: m_bytes = 3'd4;
        endcase
        e_bytes = (n_bytes < m_bytes) ? n_bytes : m_bytes;
        offs    = addr_lo & 2'(m_bytes - 3'd1) & ~2'(e_bytes - 3'd1);
        sh_big  = 3'd4 - {1'b0, offs} - e_bytes;
        sh      = big ? sh_big[1:0] : offs;
        unique case (e_bytes)
            3'd1:    bmask = 4'b0001;
            3'd2:    bmask = 4'b0011;
            default: bmask = 4'b1111;
        endcase
    end

    for (genvar b = 0; b < LANES; b++) begin : g_emask
        assign emask[8*b +: 8] = {8{bmask[b]}};
    end

    assign bus_wdata = (wdata & emask) << {sh, 3'b000};
    assign bus_be    = (be & bmask) << sh;
    assign rdata     = (bus_in >> {sh, 3'b000}) & emask;
endmodule

// File: rtl/amc_seq.sv
module amc_seq
    import amc_pkg::*;
#(
    parameter int CW = 4,
    parameter int HW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic [CW-1:0] cfg_turn,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_strobe,
    input  logic [HW-1:0] cfg_hold,
    input  logic          rdy,
    output amc_state_e    state,
    output logic          is_wr,
    output logic          cap_en,
    output logic          fin
);
    amc_state_e    state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          last_rd;
    logic [CW-1:0] setup_len, strobe_len;

    assign setup_len  = (cfg_setup  == '0) ? CW'(1) : cfg_setup;
    assign strobe_len = (cfg_strobe == '0) ? CW'(1) : cfg_strobe;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        fin       = 1'b0;
        cap_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (start_wr && last_rd && cfg_turn != '0) begin
                        state_nxt = ST_TURN;
                        cnt_nxt   = cfg_turn;
                    end else begin
                        state_nxt = ST_SETUP;
                        cnt_nxt   = setup_len;
                    end
                end
            end
            ST_TURN: begin
                if (cnt == CW'(1)) begin
                    state_nxt = ST_SETUP;
                    cnt_nxt   = setup_len;
                end else begin
                    cnt_nxt = cnt - CW'(1);
                end
            end
            ST_SETUP: begin
                if (cnt == CW'(1)) begin
                    state_nxt = ST_STROBE;
                    cnt_nxt   = strobe_len;
                end else begin
                    cnt_nxt = cnt - CW'(1);
                end
            end
            ST_STROBE: begin
                if (cnt == CW'(1)) begin
                    if (rdy) begin
                        cap_en = !is_wr;
                        if (cfg_hold == '0) begin
                            state_nxt = ST_IDLE;
                            fin       = 1'b1;
                        end else begin
                            state_nxt = ST_HOLD;
                            cnt_nxt   = CW'(cfg_hold);
                        end
                    end
                end else begin
                    cnt_nxt = cnt - CW'(1);
                end
            end
            ST_HOLD: begin
                if (cnt == CW'(1)) begin
                    state_nxt = ST_IDLE;
                    fin       = 1'b1;
                end else begin
                    cnt_nxt = cnt - CW'(1);
                end
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            is_wr   <= 1'b0;
            last_rd <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (state == ST_IDLE && start) is_wr <= start_wr;
            if (fin) last_rd <= !is_wr;
        end
    end

    // Wait state keeps the strobe on its final count (R6)
    assert_wait_extends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && cnt == CW'(1) && !rdy) |=> (state == ST_STROBE && cnt == CW'(1)));

    // A write entering setup straight from idle was not owed a gap (R8)
    assert_no_skipped_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && $past(state) == ST_IDLE && is_wr) |-> ($past(!last_rd) || $past(cfg_turn) == '0));
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
    import amc_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 4,
    parameter int HW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [AW-1:0]    req_addr,
    input  logic [31:0]      req_wdata,
    input  logic [3:0]       req_be,
    output logic             done,
    output logic [31:0]      rdata,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_big_endian,
    input  logic [CW-1:0]    cfg_setup,
    input  logic [CW-1:0]    cfg_strobe,
    input  logic [CW-1:0]    cfg_turn,
    input  logic [HW-1:0]    cfg_hold,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [31:0]      mem_dq_in,
    output logic             mem_oe_n,
    output logic             mem_re_n,
    output logic             mem_we_n,
    output logic [3:0]       mem_be_n,
    input  logic             mem_rdy
);
    amc_state_e       state;
    logic             is_wr, cap_en, fin, accept, active;
    logic [1:0]       size_q;
    logic [31:0]      wdata_q, lane_rdata;
    logic [3:0]       be_q, lane_be;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            size_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            rdata    <= '0;
            done     <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                size_q   <= req_size;
                wdata_q  <= req_wdata;
                be_q     <= req_be;
            end
            if (cap_en) rdata <= lane_rdata;
            done <= fin;
        end
    end

    amc_seq #(.CW(CW), .HW(HW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_wr   (req_write),
        .cfg_turn   (cfg_turn),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .cfg_hold   (cfg_hold),
        .rdy        (mem_rdy),
        .state      (state),
        .is_wr      (is_wr),
        .cap_en     (cap_en),
        .fin        (fin)
    );

    amc_lanes u_lanes (
        .size      (size_q),
        .width     (cfg_width),
        .big       (cfg_big_endian),
        .addr_lo   (mem_addr[1:0]),
        .wdata     (wdata_q),
        .be        (be_q),
        .bus_in    (mem_dq_in),
        .bus_wdata (mem_dq_out),
        .bus_be    (lane_be),
        .rdata     (lane_rdata)
    );

    always_comb begin
        active    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        req_ready = (state == ST_IDLE);
        mem_oe_n  = !(active && !is_wr);
        mem_re_n  = !(state == ST_STROBE && !is_wr);
        mem_we_n  = !(state == ST_STROBE && is_wr);
        mem_dq_oe = active && is_wr;
        mem_be_n  = active ? ~lane_be : 4'hF;
    end

    assert_oe_covers_re_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re_n |-> !mem_oe_n);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    assert_no_drive_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_we_has_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_turn_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |-> (mem_oe_n && mem_we_n && !mem_dq_oe && mem_be_n == 4'hF));

    assert_addr_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

    assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_async_mem_ctrl.sv
module sim_async_mem_ctrl;
    localparam int AW = 20;
    localparam int CW = 4;
    localparam int HW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    req_be = '0;
    logic          done;
    logic [31:0]   rdata;
    logic [1:0]    cfg_width = 2'd2;
    logic          cfg_big_endian = 1'b0;
    logic [CW-1:0] cfg_setup = 4'd1, cfg_strobe = 4'd1, cfg_turn = 4'd0;
    logic [HW-1:0] cfg_hold = 3'd0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_dq_out, mem_dq_in = '0;
    logic          mem_dq_oe, mem_oe_n, mem_re_n, mem_we_n, mem_rdy = 1'b1;
    logic [3:0]    mem_be_n;

    async_mem_ctrl #(.AW(AW), .CW(CW), .HW(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .done(done), .rdata(rdata),
        .cfg_width(cfg_width), .cfg_big_endian(cfg_big_endian), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_turn(cfg_turn), .cfg_hold(cfg_hold),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_rdy(mem_rdy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit prev_rd = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Lane from device byte address, written per byte address
    function automatic int lane_of(int i, int ne, int o, bit big);
        int a;
        a = big ? (o + ne - 1 - i) : (o + i);
        return big ? (3 - a) : a;
    endfunction

    task automatic access(input bit wr, input int sz, input int wd, input bit big,
                          input logic [AW-1:0] addr, input logic [31:0] wdat,
                          input logic [3:0] be, input int su, input int st,
                          input int ho, input int tu, input int waits);
        int m, n, ne, o, T, S, K0, N;
        logic [31:0] pat, exp_bus, mask32, exp_rd;
        logic [3:0]  exp_ben;
        string lt;
        m  = (wd == 0) ? 1 : (wd == 1) ? 2 : 4;
        n  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        ne = (n < m) ? n : m;
        o  = ((int'(addr[1:0]) % m) / ne) * ne;
        T  = (wr && prev_rd) ? tu : 0;
        S  = (su < 1) ? 1 : su;
        K0 = (st < 1) ? 1 : st;
        N  = T + S + K0 + waits + ho;
        pat = $urandom;
        exp_bus = '0; mask32 = '0; exp_rd = '0; exp_ben = 4'hF;
        for (int i = 0; i < ne; i++) begin
            int L;
            L = lane_of(i, ne, o, big);
            mask32[8*L +: 8] = 8'hFF;
            exp_bus[8*L +: 8] = wdat[8*i +: 8];
            exp_rd[8*i +: 8]  = pat[8*L +: 8];
            if (be[i]) exp_ben[L] = 1'b0;
        end
        lt = big ? "R11" : "R10";

        cfg_width = 2'(wd); cfg_big_endian = big;
        cfg_setup = CW'(su); cfg_strobe = CW'(st); cfg_hold = HW'(ho); cfg_turn = CW'(tu);
        req_write = wr; req_size = 2'(sz); req_addr = addr; req_wdata = wdat; req_be = be;
        mem_dq_in = pat; mem_rdy = 1'b1;
        chk("R1 ready before accept", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k <= N; k++) begin
            bit in_str, in_act;
            int j;
            in_str = (k >= T + S) && (k < T + S + K0 + waits);
            in_act = (k >= T) && (k < N);
            j = k - T - S;
            mem_rdy = !(in_str && j >= K0 - 1 && j < K0 - 1 + waits);
            if (k == 0) chk("R7 done low at start", 32'(done), 32'd0);
            if (k < N) begin
                chk("R1 busy", 32'(req_ready), 32'd0);
                chk(T > 0 && k < T ? "R8 oe_n" : "R3 oe_n", 32'(mem_oe_n), 32'(!(in_act && !wr)));
                chk(waits > 0 ? "R6 re_n" : "R4 re_n", 32'(mem_re_n), 32'(!(in_str && !wr)));
                chk(waits > 0 ? "R6 we_n" : "R5 we_n", 32'(mem_we_n), 32'(!(in_str && wr)));
                chk(T > 0 && k < T ? "R8 dq_oe" : "R9 dq_oe", 32'(mem_dq_oe), 32'(in_act && wr));
                chk("R12 be_n", 32'(mem_be_n), 32'(in_act ? exp_ben : 4'hF));
                chk("R14 addr", 32'(mem_addr), 32'(addr));
                if (in_str && wr) chk({lt, " write lanes"}, mem_dq_out & mask32, exp_bus);
                @(negedge clk);
            end else begin
                chk("R2 done after phases", 32'(done), 32'd1);
                chk("R1 ready after done", 32'(req_ready), 32'd1);
                chk("R3 oe_n idle", 32'(mem_oe_n), 32'd1);
                chk("R12 be_n idle", 32'(mem_be_n), 32'hF);
                if (!wr) begin
                    chk({lt, " R13 rdata"}, rdata, exp_rd);
                end
            end
        end
        mem_rdy = 1'b1;
        prev_rd = !wr;
    endtask

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", 32'(req_ready), 32'd1);
        chk("R3 reset oe_n", 32'(mem_oe_n), 32'd1);
        chk("R4 reset re_n", 32'(mem_re_n), 32'd1);
        chk("R5 reset we_n", 32'(mem_we_n), 32'd1);
        chk("R9 reset dq_oe", 32'(mem_dq_oe), 32'd0);
        chk("R12 reset be_n", 32'(mem_be_n), 32'hF);
        chk("R7 reset done", 32'(done), 32'd0);

        // Lane placement sweep with read/write alternation
        idx = 0;
        for (int big = 0; big < 2; big++)
            for (int wd = 0; wd < 3; wd++)
                for (int sz = 0; sz < 3; sz++)
                    for (int off = 0; off < 4; off++)
                        for (int wr = 0; wr < 2; wr++) begin
                            logic [AW-1:0] a;
                            a = AW'($urandom);
                            a[1:0] = 2'(off);
                            access(bit'(wr), sz, wd, bit'(big), a, $urandom, 4'($urandom),
                                   idx % 4, 1 + idx % 3, idx % 3, idx % 4, idx % 3);
                            idx++;
                        end

        // Timing sweep
        for (int su = 0; su < 4; su++)
            for (int st = 1; st < 4; st++)
                for (int ho = 0; ho < 4; ho++)
                    for (int w = 0; w < 3; w++) begin
                        access(bit'((su + st + ho + w) % 2), 2, 2, 1'b0, AW'($urandom), $urandom,
                               4'hF, su, st, ho, 2, w);
                    end

        // Turnaround cases: write after write, read then write, long phases
        access(1'b1, 2, 2, 1'b0, AW'(20'h00100), 32'h11223344, 4'hF, 1, 1, 0, 5, 0);
        access(1'b1, 2, 2, 1'b0, AW'(20'h00104), 32'h55667788, 4'hF, 1, 1, 0, 5, 0);
        access(1'b0, 2, 2, 1'b0, AW'(20'h00108), 32'h0, 4'hF, 1, 1, 0, 5, 0);
        access(1'b1, 2, 2, 1'b0, AW'(20'h0010C), 32'h99AABBCC, 4'h5, 1, 1, 0, 15, 0);
        access(1'b0, 1, 1, 1'b1, AW'(20'h00202), 32'h0, 4'h3, 15, 15, 7, 0, 3);
        access(1'b1, 1, 1, 1'b1, AW'(20'h00202), 32'hDEADBEEF, 4'h2, 15, 15, 7, 0, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule